// File: doc/BRIEF.md
# Edge-Triggered Interrupt Status Controller

This block gathers nine interrupt sources into one status word and drives a single interrupt request line. The sources are two fill-level thresholds of a FIFO, three timer overflow pulses and four external input lines. A source can latch its status bit only when its enable bit is set. It latches only on the transition from inactive to active, so a source that stays active does not raise a second request.

Software reaches the block through one register offset. A write to that offset loads the enable word. A read from that offset returns the status word and clears the bits it returned. The request line is high exactly while some status bit is set, so a zero status word tells the handler that this block did not cause a shared interrupt.

Top module: `irq_status_ctrl`

## Requirements
- R1: Status and enable bit positions are fixed. Bit 0 is fill above half depth, bit 1 is fill above three quarters of depth, bits 2, 3 and 4 are timer overflow 0, 1 and 2, bits 5 to 8 are external lines 0 to 3, and bits 9 to 15 always read as zero.
- R2: A read strobe at offset REG_OFS puts the status word on `bus_rdata` after the next clock edge. A read at any other offset returns zero and leaves the status unchanged.
- R3: A write strobe at offset REG_OFS loads bits 8:0 of `bus_wdata` into the enable word. Writes to bits 15:9 have no effect.
- R4: A source whose enable bit is 0 never sets its status bit.
- R5: A status bit is set only on the inactive-to-active transition of its source. A source held active sets its bit again only after it has gone inactive and then active again.
- R6: Sources that become active in the same cycle set all of their status bits in that same cycle.
- R7: `irq` is high if and only if the status word is non-zero.
- R8: A status read clears every bit that was set when the read occurred. A new edge in the read cycle stays latched, including an edge on a bit that is being cleared.
- R9: The fill thresholds use strict comparisons, `fifo_fill > FIFO_DEPTH/2` and `fifo_fill > 3*FIFO_DEPTH/4`. Each one triggers on the cycle in which its comparison becomes true.
- R10: A timer pulse sets its bit at the clock edge that samples it. An external line passes through a two-flop synchronizer, so its bit and `irq` rise at the third clock edge after the line goes high.
- R11: Clearing an enable bit does not clear a status bit that is already latched.
- R12: Reset clears the status word, the enable word, `bus_rdata` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | WORD_W | Write data (enable word) |
| bus_rdata | output | WORD_W | Registered read data (status word) |
| fifo_fill | input | CNT_W | Current FIFO fill count |
| tmr_wrap | input | 3 | Single-cycle timer overflow pulses |
| ext_line | input | 4 | Asynchronous external request lines |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with FIFO_DEPTH = 8, which gives thresholds of 4 and 6. At that depth every fill count from 0 to 8 can be swept, and both strict boundaries fall inside the sweep. All eight enable patterns of the timer group are also swept. The bench measures the synchronizer latency of each external line one edge at a time. It also sets up the cases where a read and a new edge meet in the same cycle, both on the same bit and on different bits.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_TMR  = 3;
  localparam int N_EXT  = 4;
  localparam int N_LVL  = 2;
  localparam int N_SRC  = N_LVL + N_TMR + N_EXT;
  localparam int B_LVL  = 0;
  localparam int B_TMR  = B_LVL + N_LVL;
  localparam int B_EXT  = B_TMR + N_TMR;

  typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_level_edge.sv
module irq_level_edge #(
  parameter int DEPTH = 1024,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fill,
  output logic [1:0]       rise
);
  localparam logic [CNT_W-1:0] HALF  = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] THREE = CNT_W'((3 * DEPTH) / 4);

  logic [1:0] above;
  logic [1:0] above_q;

  always_comb begin
    above[0] = fill > HALF;
    above[1] = fill > THREE;
  end

  always_ff @(posedge clk) begin
    if (rst) above_q <= '0;
    else     above_q <= above;
  end

  assign rise = above & ~above_q;
endmodule

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= din[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[i] = s2 & ~s3;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic [N-1:0] status,
  output logic         req
);
  logic [N-1:0] nxt;

  always_comb begin
    nxt = clr ? '0 : status;
    nxt = nxt | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      req    <= 1'b0;
    end else begin
      status <= nxt;
      req    <= |nxt;
    end
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int REG_OFS    = 6,
  parameter int FIFO_DEPTH = 1024,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  fifo_fill,
  input  logic [N_TMR-1:0]  tmr_wrap,
  input  logic [N_EXT-1:0]  ext_line,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);
  localparam int PAD = WORD_W - N_SRC;

  logic     sel, rd_hit, wr_hit;
  src_vec_t en_q, rise_vec, set_vec, status_q;
  logic     unused_hi;

  assign sel    = bus_addr == OFS;
  assign rd_hit = bus_rd & sel;
  assign wr_hit = bus_wr & sel;
  assign unused_hi = ^bus_wdata[WORD_W-1:N_SRC];

  irq_level_edge #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_lvl (
    .clk(clk), .rst(rst), .fill(fifo_fill),
    .rise(rise_vec[B_LVL +: N_LVL])
  );

  assign rise_vec[B_TMR +: N_TMR] = tmr_wrap;

  irq_sync_edge #(.N(N_EXT)) u_ext (
    .clk(clk), .rst(rst), .din(ext_line),
    .rise(rise_vec[B_EXT +: N_EXT])
  );

  assign set_vec = rise_vec & en_q;

  irq_status_reg #(.N(N_SRC)) u_stat (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr(rd_hit),
    .status(status_q), .req(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_hit) en_q <= bus_wdata[N_SRC-1:0];
      bus_rdata <= rd_hit ? {{PAD{1'b0}}, status_q} : '0;
    end
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_hit,
  input src_vec_t          status,
  input src_vec_t          en,
  input src_vec_t          set_vec,
  input logic [WORD_W-1:0] rdata,
  input logic              irq
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst)
    rdata[WORD_W-1:N_SRC] == '0);

  p_read_returns_r2: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> rdata[N_SRC-1:0] == $past(status));

  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status & ~$past(status) & ~$past(en)) == '0);

  p_irq_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    irq == (status != '0));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (status & $past(status) & ~$past(set_vec)) == '0);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (status & $past(status)) == $past(status));
endmodule

bind irq_status_ctrl irq_status_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .rd_hit(rd_hit), .status(status_q), .en(en_q),
  .set_vec(set_vec), .rdata(bus_rdata), .irq(irq)
);

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
  localparam int DEPTH = 8;
  localparam int CW    = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [CW-1:0] fifo_fill = '0;
  logic [2:0]  tmr_wrap = '0;
  logic [3:0]  ext_line = '0;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  irq_status_ctrl #(.FIFO_DEPTH(DEPTH), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_fill(fifo_fill),
    .tmr_wrap(tmr_wrap), .ext_line(ext_line), .irq(irq)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a; bus_rd = 1'b1; step(); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic wr(input logic [15:0] d);
    bus_addr = 4'd6; bus_wdata = d; bus_wr = 1'b1; step(); bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] p);
    tmr_wrap = p; step(); tmr_wrap = '0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step(); step(); rst = 1'b0; step();
    // R12 reset state
    chk("R12 irq", {15'd0, irq}, 16'd0);
    chk("R12 rdata", bus_rdata, 16'd0);
    // R4 / R12: enable resets to zero, so nothing latches
    pulse(3'b111); fifo_fill = 4'd8; ext_line = 4'hF;
    repeat (4) step();
    rd(4'd6, rv); chk("R4 disabled", rv, 16'd0);
    fifo_fill = '0; ext_line = '0; repeat (4) step();
    // R3 reserved-only write leaves enables zero
    wr(16'hFE00); pulse(3'b111); rd(4'd6, rv); chk("R3 reserved write", rv, 16'd0);
    wr(16'hFFFF);
    // R9 fifo sweep
    for (int c = 0; c <= DEPTH; c++) begin
      fifo_fill = CW'(c); step();
      chk("R7 irq fifo", {15'd0, irq}, {15'd0, c > DEPTH / 2});
      rd(4'd6, rv);
      chk("R9 R1 fifo level", rv, 16'((c > DEPTH / 2) ? 1 : 0) | 16'((c > 3 * DEPTH / 4) ? 2 : 0));
      fifo_fill = '0; step();
      rd(4'd6, rv); chk("R5 fifo fall", rv, 16'd0);
    end
    // R10 R1 timers
    for (int t = 0; t < 3; t++) begin
      pulse(3'(1 << t));
      chk("R10 timer irq", {15'd0, irq}, 16'd1);
      rd(4'd6, rv); chk("R1 timer bit", rv, 16'(1 << (2 + t)));
      chk("R7 irq cleared", {15'd0, irq}, 16'd0);
    end
    // R10 R1 external lines
    for (int e = 0; e < 4; e++) begin
      ext_line = 4'(1 << e); step(); step();
      chk("R10 ext early", {15'd0, irq}, 16'd0);
      step();
      chk("R10 ext latency", {15'd0, irq}, 16'd1);
      rd(4'd6, rv); chk("R1 ext bit", rv, 16'(1 << (5 + e)));
      // R5 held line gives no new request
      repeat (6) step();
      rd(4'd6, rv); chk("R5 held", rv, 16'd0);
      ext_line = '0; repeat (4) step();
    end
    // R6 simultaneous sources
    fifo_fill = 4'd8; tmr_wrap = 3'b111; step(); tmr_wrap = '0;
    rd(4'd6, rv); chk("R6 together", rv, 16'h001F);
    fifo_fill = '0; step();
    // R4 enable mask sweep over timers
    for (int m = 0; m < 8; m++) begin
      wr(16'(m << 2)); pulse(3'b111);
      rd(4'd6, rv); chk("R4 mask", rv, 16'(m << 2));
    end
    // R11 disabling keeps latched bit
    wr(16'h0004); pulse(3'b001); wr(16'h0000);
    chk("R11 irq kept", {15'd0, irq}, 16'd1);
    rd(4'd6, rv); chk("R11 latched", rv, 16'h0004);
    // R2 other offset returns zero, no clear
    wr(16'h001C); pulse(3'b010);
    rd(4'd5, rv); chk("R2 other offset", rv, 16'd0);
    rd(4'd6, rv); chk("R2 status read", rv, 16'h0008);
    // R8 edge on another bit during read
    pulse(3'b001);
    bus_addr = 4'd6; bus_rd = 1'b1; tmr_wrap = 3'b010; step();
    bus_rd = 1'b0; tmr_wrap = '0; rv = bus_rdata;
    chk("R8 read value", rv, 16'h0004);
    rd(4'd6, rv); chk("R8 other bit kept", rv, 16'h0008);
    // R8 edge on same bit during read
    pulse(3'b001);
    bus_addr = 4'd6; bus_rd = 1'b1; tmr_wrap = 3'b001; step();
    bus_rd = 1'b0; tmr_wrap = '0;
    chk("R8 same read", bus_rdata, 16'h0004);
    rd(4'd6, rv); chk("R8 same bit kept", rv, 16'h0004);
    // R12 reset mid-run
    pulse(3'b100); rst = 1'b1; step(); rst = 1'b0; step();
    chk("R12 irq after reset", {15'd0, irq}, 16'd0);
    pulse(3'b111); rd(4'd6, rv); chk("R12 enable cleared", rv, 16'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule